// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block gives two independent agents, a left port and a right port, a set of eight single-bit hardware locks that they share. Software on either side claims a lock by writing 0 to it and gives it back by writing 1. A read shows that port whether it holds the lock. Only one side can hold a given lock at a time. A claim that finds the lock taken waits in a queue of depth one and is granted as soon as the holder lets go. The design runs on a single clock and is fully synchronous.

Each lock is a five-state machine. The states are:
- FREE: nobody holds the lock.
- LEFT: the left port holds it.
- RIGHT: the right port holds it.
- LEFT_RQ: the left port holds it and the right port is queued.
- RIGHT_LQ: the right port holds it and the left port is queued.

The transitions are:
- claim: FREE to LEFT, FREE to RIGHT, or FREE to LEFT_RQ when both ports claim in the same cycle.
- queue: LEFT to LEFT_RQ, RIGHT to RIGHT_LQ.
- release-free: LEFT or RIGHT to FREE, or either queued state to FREE when both ports write 1 in the same cycle.
- handover: LEFT_RQ to RIGHT, RIGHT_LQ to LEFT, LEFT to RIGHT, RIGHT to LEFT.
- withdraw: LEFT_RQ to LEFT, RIGHT_LQ to RIGHT.

Every other input leaves the state unchanged.

Top module: `dps_sema_unit`

## Requirements
- R1: After reset every lock is FREE with no queued claim, and both read-data outputs are all ones.
- R2: A port has no access while its enable input (`*_sem_n`) is high. Its writes change nothing, and its read-data output keeps its last value.
- R3: The 3-bit select input picks the lock that is accessed. Locks that are not selected keep their state.
- R4: A write acts on data bit 0 alone. Bit 0 = 0 claims the lock and bit 0 = 1 releases it. Bits 7..1 have no effect.
- R5: A read with enable low and the write strobe low loads read data on the next clock edge. It loads all zeros if that port holds the selected lock at the time of the read, and all ones otherwise. The value holds until the next read.
- R6: If both ports claim the same FREE lock in the same cycle, the left port is granted and the right port's claim is queued.
- R7: When the holder releases while the other side has a claim queued, the other side holds the lock from the next clock. The same applies when the other side claims in the same cycle as the release.
- R8: A claim by the port that already holds the lock leaves the lock's state unchanged.
- R9: A queued port that writes 1 withdraws its claim. A later release by the holder then leaves the lock FREE.
- R10: No lock is ever held by both ports at once.
- R11: A release by a port that neither holds nor is queued on the lock has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sem_n | input | 1 | Left port lock access enable, active low |
| l_we | input | 1 | Left port write strobe: 1 = write, 0 = read |
| l_sel | input | 3 | Left port lock select |
| l_wdata | input | 8 | Left port write data; only bit 0 is used |
| l_rdata | output | 8 | Left port read data, registered |
| r_sem_n | input | 1 | Right port lock access enable, active low |
| r_we | input | 1 | Right port write strobe: 1 = write, 0 = read |
| r_sel | input | 3 | Right port lock select |
| r_wdata | input | 8 | Right port write data; only bit 0 is used |
| r_rdata | output | 8 | Right port read data, registered |

## Verification
The bench builds the block with its default parameters: eight locks and an 8-bit data path. With eight locks, random selects from both ports often collide on the same lock. That drives simultaneous claims, releases that coincide with queued claims, and withdrawals in the same cycle. Each of the five states and every transition between them is therefore reached many times. Because the data path is 8 bits wide, the bench can fill bits 7..1 of the write data with random values, to show that they have no effect, and can check that read data is replicated across every bit.

// File: rtl/dps_pkg.sv
package dps_pkg;

    // Per-lock arbitration state
    typedef enum logic [2:0] {
        SEM_FREE     = 3'd0,
        SEM_LEFT     = 3'd1,
        SEM_RIGHT    = 3'd2,
        SEM_LEFT_RQ  = 3'd3,   // left holds, right queued
        SEM_RIGHT_LQ = 3'd4    // right holds, left queued
    } sem_state_e;

    // Decoded per-lock command from one port
    typedef struct packed {
        logic claim;
        logic drop;
    } sem_cmd_t;

endpackage

// File: rtl/dps_port_decode.sv
module dps_port_decode #(
    parameter int NUM_SEMA = 8,
    parameter int SEL_W    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sem_n,
    input  logic                         we,
    input  logic [SEL_W-1:0]             sel,
    input  logic                         wbit,
    output dps_pkg::sem_cmd_t [NUM_SEMA-1:0] cmd,
    output logic                         rd_en
);
    import dps_pkg::*;

    logic access;
    assign access = ~sem_n;
    assign rd_en  = access & ~we;

    for (genvar gi = 0; gi < NUM_SEMA; gi++) begin : g_dec
        logic hit;
        assign hit            = access & we & (sel == SEL_W'(gi));
        assign cmd[gi].claim  = hit & ~wbit;
        assign cmd[gi].drop   = hit &  wbit;
    end

    // R3: at most one lock is addressed per port per cycle
    logic [NUM_SEMA-1:0] touched;
    for (genvar gj = 0; gj < NUM_SEMA; gj++) begin : g_touch
        assign touched[gj] = cmd[gj].claim | cmd[gj].drop;
    end

    p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(touched));

    p_read_not_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (touched == '0));

endmodule

// File: rtl/dps_sema_cell.sv
module dps_sema_cell (
    input  logic              clk,
    input  logic              rst_n,
    input  dps_pkg::sem_cmd_t lcmd,
    input  dps_pkg::sem_cmd_t rcmd,
    output logic              held_l,
    output logic              held_r
);
    import dps_pkg::*;

    sem_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEM_FREE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEM_FREE: begin
                if (lcmd.claim && rcmd.claim) state_d = SEM_LEFT_RQ;
                else if (lcmd.claim)          state_d = SEM_LEFT;
                else if (rcmd.claim)          state_d = SEM_RIGHT;
            end
            SEM_LEFT: begin
                if (lcmd.drop && rcmd.claim)  state_d = SEM_RIGHT;
                else if (lcmd.drop)           state_d = SEM_FREE;
                else if (rcmd.claim)          state_d = SEM_LEFT_RQ;
            end
            SEM_RIGHT: begin
                if (rcmd.drop && lcmd.claim)  state_d = SEM_LEFT;
                else if (rcmd.drop)           state_d = SEM_FREE;
                else if (lcmd.claim)          state_d = SEM_RIGHT_LQ;
            end
            SEM_LEFT_RQ: begin
                if (lcmd.drop && rcmd.drop)   state_d = SEM_FREE;
                else if (lcmd.drop)           state_d = SEM_RIGHT;
                else if (rcmd.drop)           state_d = SEM_LEFT;
            end
            SEM_RIGHT_LQ: begin
                if (lcmd.drop && rcmd.drop)   state_d = SEM_FREE;
                else if (rcmd.drop)           state_d = SEM_LEFT;
                else if (lcmd.drop)           state_d = SEM_RIGHT;
            end
            default:                          state_d = SEM_FREE;
        endcase
    end

    // Output decode
    always_comb begin
        held_l = 1'b0;
        held_r = 1'b0;
        unique case (state_q)
            SEM_LEFT, SEM_LEFT_RQ:   held_l = 1'b1;
            SEM_RIGHT, SEM_RIGHT_LQ: held_r = 1'b1;
            default: ;
        endcase
    end

    logic l_queued, r_queued;
    assign l_queued = (state_q == SEM_RIGHT_LQ);
    assign r_queued = (state_q == SEM_LEFT_RQ);

    p_left_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_l && !held_r && lcmd.claim && rcmd.claim) |=> (held_l && r_queued));

    p_handover_l2r_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_queued && lcmd.drop && !rcmd.drop) |=> held_r);

    p_handover_r2l_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (l_queued && rcmd.drop && !lcmd.drop) |=> held_l);

    p_reclaim_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (held_l && lcmd.claim && !rcmd.claim && !rcmd.drop) |=> $stable(state_q));

    p_withdraw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_queued && rcmd.drop && !lcmd.drop) |=> (held_l && !r_queued));

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(lcmd.claim || lcmd.drop || rcmd.claim || rcmd.drop) |=> $stable(state_q));

    p_stray_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (held_r && !l_queued && lcmd.drop && !rcmd.claim && !rcmd.drop) |=> $stable(state_q));

endmodule

// File: rtl/dps_readback.sv
module dps_readback #(
    parameter int NUM_SEMA = 8,
    parameter int SEL_W    = 3,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [SEL_W-1:0]    sel,
    input  logic [NUM_SEMA-1:0] held,
    output logic [DATA_W-1:0]   rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '1;
        else if (rd_en) rdata <= {DATA_W{~held[sel]}};
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    p_replicated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata == '0) || (rdata == '1));

endmodule

// File: rtl/dps_sema_unit.sv
module dps_sema_unit #(
    parameter int  NUM_SEMA = 8,
    parameter int  DATA_W   = 8,
    localparam int SEL_W    = (NUM_SEMA > 1) ? $clog2(NUM_SEMA) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sem_n,
    input  logic              l_we,
    input  logic [SEL_W-1:0]  l_sel,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sem_n,
    input  logic              r_we,
    input  logic [SEL_W-1:0]  r_sel,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    import dps_pkg::*;

    sem_cmd_t [NUM_SEMA-1:0] lcmd, rcmd;
    logic                    l_rd, r_rd;
    logic [NUM_SEMA-1:0]     held_l, held_r;

    dps_port_decode #(.NUM_SEMA(NUM_SEMA), .SEL_W(SEL_W)) i_dec_l (
        .clk(clk), .rst_n(rst_n), .sem_n(l_sem_n), .we(l_we), .sel(l_sel),
        .wbit(l_wdata[0]), .cmd(lcmd), .rd_en(l_rd)
    );

    dps_port_decode #(.NUM_SEMA(NUM_SEMA), .SEL_W(SEL_W)) i_dec_r (
        .clk(clk), .rst_n(rst_n), .sem_n(r_sem_n), .we(r_we), .sel(r_sel),
        .wbit(r_wdata[0]), .cmd(rcmd), .rd_en(r_rd)
    );

    for (genvar gs = 0; gs < NUM_SEMA; gs++) begin : g_sema
        dps_sema_cell i_cell (
            .clk(clk), .rst_n(rst_n),
            .lcmd(lcmd[gs]), .rcmd(rcmd[gs]),
            .held_l(held_l[gs]), .held_r(held_r[gs])
        );
    end

    dps_readback #(.NUM_SEMA(NUM_SEMA), .SEL_W(SEL_W), .DATA_W(DATA_W)) i_rb_l (
        .clk(clk), .rst_n(rst_n), .rd_en(l_rd), .sel(l_sel),
        .held(held_l), .rdata(l_rdata)
    );

    dps_readback #(.NUM_SEMA(NUM_SEMA), .SEL_W(SEL_W), .DATA_W(DATA_W)) i_rb_r (
        .clk(clk), .rst_n(rst_n), .rd_en(r_rd), .sel(r_sel),
        .held(held_r), .rdata(r_rdata)
    );

    p_mutex_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (held_l & held_r) == '0);

    p_disabled_l_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sem_n && r_sem_n) |=> ($stable(held_l) && $stable(held_r)));

endmodule

// File: tb/test_dps_sema_unit.sv
`timescale 1ns/1ps
module test_dps_sema_unit;

    localparam int N  = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_sem_n = 1'b1, l_we = 1'b0, r_sem_n = 1'b1, r_we = 1'b0;
    logic [2:0]    l_sel = '0, r_sel = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Reference model: owner/waiter 0 = none, 1 = left, 2 = right
    int            owner  [N];
    int            waiter [N];
    logic [DW-1:0] exp_l = '1, exp_r = '1;

    always #2 clk = ~clk;

    dps_sema_unit #(.NUM_SEMA(N), .DATA_W(DW)) i_dps_sema_unit (
        .clk(clk), .rst_n(rst_n),
        .l_sem_n(l_sem_n), .l_we(l_we), .l_sel(l_sel), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sem_n(r_sem_n), .r_we(r_we), .r_sel(r_sel), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] read_val(input int s, input int side);
        return (owner[s] == side) ? '0 : '1;
    endfunction

    // One cycle: drive at negedge, model per requirements, check after the edge
    task automatic step(input string tag,
                        input logic lsn, input logic lwe, input logic [2:0] ls, input logic [DW-1:0] lwd,
                        input logic rsn, input logic rwe, input logic [2:0] rs, input logic [DW-1:0] rwd);
        int no [N];
        int nw [N];
        l_sem_n = lsn; l_we = lwe; l_sel = ls; l_wdata = lwd;
        r_sem_n = rsn; r_we = rwe; r_sel = rs; r_wdata = rwd;
        if (!lsn && !lwe) exp_l = read_val(ls, 1);    // R5
        if (!rsn && !rwe) exp_r = read_val(rs, 2);
        for (int s = 0; s < N; s++) begin
            bit lc, ld, rc, rd, want;
            lc = !lsn && lwe && ls == 3'(s) && !lwd[0];   // R4
            ld = !lsn && lwe && ls == 3'(s) &&  lwd[0];
            rc = !rsn && rwe && rs == 3'(s) && !rwd[0];
            rd = !rsn && rwe && rs == 3'(s) &&  rwd[0];
            no[s] = owner[s];
            nw[s] = waiter[s];
            if (owner[s] == 0) begin
                if (lc) begin no[s] = 1; nw[s] = rc ? 2 : 0; end   // R6
                else if (rc) no[s] = 2;
            end else if (owner[s] == 1) begin
                want = (waiter[s] == 2) ? !rd : rc;                   // R9
                if (ld) begin no[s] = want ? 2 : 0; nw[s] = 0; end    // R7
                else nw[s] = want ? 2 : 0;                            // R8
            end else begin
                want = (waiter[s] == 1) ? !ld : lc;                   // R11 via want
                if (rd) begin no[s] = want ? 1 : 0; nw[s] = 0; end
                else nw[s] = want ? 1 : 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int s = 0; s < N; s++) begin owner[s] = no[s]; waiter[s] = nw[s]; end
        check({tag, " left"},  l_rdata, exp_l);
        check({tag, " right"}, r_rdata, exp_r);
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b1, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 3'd0, 8'h00);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int s = 0; s < N; s++) begin owner[s] = 0; waiter[s] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values and every lock free
        check("R1 reset left",  l_rdata, 8'hFF);
        check("R1 reset right", r_rdata, 8'hFF);
        for (int s = 0; s < N; s++)
            step("R1 free", 1'b0, 1'b0, 3'(s), 8'h00, 1'b0, 1'b0, 3'(s), 8'h00);

        // R2: claim with enable high is ignored
        step("R2 setup", 1'b1, 1'b1, 3'd2, 8'h00, 1'b1, 1'b0, 3'd0, 8'h00);
        step("R2 read",  1'b0, 1'b0, 3'd2, 8'h00, 1'b1, 1'b0, 3'd0, 8'h00);
        check("R2 disabled write", l_rdata, 8'hFF);

        // R4: upper data bits ignored; bit0=0 claims
        step("R4 claim", 1'b0, 1'b1, 3'd5, 8'hFE, 1'b1, 1'b0, 3'd0, 8'h00);
        step("R4 read",  1'b0, 1'b0, 3'd5, 8'h00, 1'b1, 1'b0, 3'd0, 8'h00);
        check("R4 claim bit0", l_rdata, 8'h00);

        // R5: right queues, reads ones
        step("R5 queue", 1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 3'd5, 8'h00);
        step("R5 read",  1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 3'd5, 8'h00);
        check("R5 not holder", r_rdata, 8'hFF);

        // R7: left releases with 0x01, right gets it
        step("R7 rel",  1'b0, 1'b1, 3'd5, 8'h01, 1'b1, 1'b0, 3'd0, 8'h00);
        step("R7 read", 1'b0, 1'b0, 3'd5, 8'h00, 1'b0, 1'b0, 3'd5, 8'h00);
        check("R7 handover right", r_rdata, 8'h00);
        check("R7 handover left",  l_rdata, 8'hFF);

        // R8: holder claims again
        step("R8 reclaim", 1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 3'd5, 8'h00);
        step("R8 read",    1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 3'd5, 8'h00);
        check("R8 still held", r_rdata, 8'h00);

        // R3: neighbouring lock unaffected
        step("R3 read", 1'b0, 1'b0, 3'd4, 8'h00, 1'b0, 1'b0, 3'd4, 8'h00);
        check("R3 other lock", r_rdata, 8'hFF);

        // R11: stray release by left on lock 5
        step("R11 stray", 1'b0, 1'b1, 3'd5, 8'hFF, 1'b1, 1'b0, 3'd0, 8'h00);
        step("R11 read",  1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 3'd5, 8'h00);
        check("R11 no effect", r_rdata, 8'h00);

        // R6: simultaneous claim on lock 3
        step("R6 claim", 1'b0, 1'b1, 3'd3, 8'h00, 1'b0, 1'b1, 3'd3, 8'h00);
        step("R6 read",  1'b0, 1'b0, 3'd3, 8'h00, 1'b0, 1'b0, 3'd3, 8'h00);
        check("R6 left wins",   l_rdata, 8'h00);
        check("R6 right waits", r_rdata, 8'hFF);

        // R9: right withdraws, left releases, lock free
        step("R9 withdraw", 1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 3'd3, 8'h01);
        step("R9 release",  1'b0, 1'b1, 3'd3, 8'h01, 1'b1, 1'b0, 3'd0, 8'h00);
        step("R9 read",     1'b0, 1'b0, 3'd3, 8'h00, 1'b0, 1'b0, 3'd3, 8'h00);
        check("R9 free left",  l_rdata, 8'hFF);
        check("R9 free right", r_rdata, 8'hFF);

        // R2: read data holds while disabled
        step("R2 claim6", 1'b0, 1'b1, 3'd6, 8'h00, 1'b1, 1'b0, 3'd0, 8'h00);
        step("R2 read6",  1'b0, 1'b0, 3'd6, 8'h00, 1'b1, 1'b0, 3'd0, 8'h00);
        idle("R2 idle");
        check("R2 hold", l_rdata, 8'h00);

        // R10 and all others: random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            step("R10 random",
                 ($urandom % 4) == 0, 1'($urandom), 3'($urandom), 8'($urandom),
                 ($urandom % 4) == 0, 1'($urandom), 3'($urandom), 8'($urandom));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule